// File: doc/BRIEF.md
# Quarter-Phase Sequencer with Reset Alignment

The block steps through four quarter phases, one per clock: Q1, Q2, Q3, Q4, then Q1 again. It is meant to sit in several places on a chip. Every copy is fed the same clock and the same release line, and after release all copies must run in step.

While the release line is low, each copy free-runs from whatever phase it holds. A copy may come out of power-up in any of the four phases. When release rises, every copy opens an alignment window. Inside that window only Q1 may last longer than one cycle. Each copy stretches its Q1 by the amount that its own starting phase calls for, so that all copies leave Q1 on the same clock. From then on they step together, and an aligned flag reports that the window has completed.

The release input has no handshake. It is a plain control level that passes through a two-stage synchronizer. Every copy has the same synchronizer, so the latency is identical in all of them.

Top module: `qps_align`

## Requirements
- R1: `phase_o` is one-hot: bit 0 is Q1, bit 1 is Q2, bit 2 is Q3 and bit 3 is Q4. At power-up the phase holds the `INIT_VEC` parameter and `aligned_o` is low.
- R2: Phases advance in the order Q1, Q2, Q3, Q4, Q1. Q2, Q3 and Q4 always last exactly one clock.
- R3: `rel_i` reaches the logic through two flops. Window cycle 0 is the cycle that begins two clock edges after the first edge that samples `rel_i` high.
- R4: While the synchronized release is low, the phase free-runs and Q1 lasts one clock.
- R5: A copy whose phase on cycle 0 is Q1, Q2, Q3 or Q4 holds Q1 for the last 2, 3, 4 or 5 cycles before cycle 10, and enters Q2 on cycle 10. A Q1 reached before cycle 5 advances after one clock.
- R6: `aligned_o` is high from window cycle 10 for as long as release stays high. It falls on the third clock edge after the first edge that samples `rel_i` low, and stays low until cycle 10 of the next window.
- R7: An illegal (non-one-hot) phase value becomes Q1 on the next clock edge.
- R8: Copies that share the clock and `rel_i` show equal phase vectors from cycle 10 onward. They stay equal through later release drops and re-releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the phase advances on each rising edge |
| rel_i | input | 1 | Release level shared by all copies; a rising level starts alignment |
| phase_o | output | 4 | One-hot quarter phase, bit 0 = Q1 through bit 3 = Q4 |
| aligned_o | output | 1 | High from window cycle 10 while release is held |

## Verification
The bench runs five copies side by side. Four start in Q1, Q2, Q3 and Q4, and the fifth starts with an illegal code. A design that stretched Q1 by a fixed amount, or counted the window from the raw input instead of the synchronized level, would leave Q2 at different cycles in different copies, and the lockstep and per-cycle phase checks would catch it. A Q1 reached early in the window, before cycle 5, must not be held. A design that held it would enter Q2 too late. The bench also drops release and raises it again: a counter that failed to clear would raise the flag too early on the second release, and a copy with no illegal-code recovery would never reach Q1.

// File: rtl/qps_pkg.sv
package qps_pkg;
  localparam int NUM_Q = 4;
  typedef logic [NUM_Q-1:0] qvec_t;
  localparam qvec_t Q1_V = 4'b0001;
  localparam qvec_t Q2_V = 4'b0010;
  localparam qvec_t Q3_V = 4'b0100;
  localparam qvec_t Q4_V = 4'b1000;
endpackage

// File: rtl/qps_rel_sync.sv
module qps_rel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rel_i,
  output logic rel_o
);
  logic [STAGES-1:0] sh_q = '0;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i) sh_q <= rel_i;
    end else begin : g_chain
      always_ff @(posedge clk_i) sh_q <= {sh_q[STAGES-2:0], rel_i};
    end
  endgenerate

  assign rel_o = sh_q[STAGES-1];
endmodule

// File: rtl/qps_win_ctr.sv
module qps_win_ctr #(
  parameter int ALIGN_CYC = 10,
  parameter int HOLD_FROM = 5
) (
  input  logic clk_i,
  input  logic rel_s_i,
  output logic hold_o,
  output logic aligned_o
);
  localparam int CNT_W = $clog2(ALIGN_CYC + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(ALIGN_CYC);
  localparam logic [CNT_W-1:0] H_LO  = CNT_W'(HOLD_FROM);
  localparam logic [CNT_W-1:0] H_HI  = CNT_W'(ALIGN_CYC - 2);

  logic [CNT_W-1:0] cnt_q = '0;

  // counts window cycles, saturates at the alignment cycle
  always_ff @(posedge clk_i) begin
    if (!rel_s_i)
      cnt_q <= '0;
    else if (cnt_q != LAST)
      cnt_q <= cnt_q + 1'b1;
  end

  // Q1 is held only when entered late in the window, up to the cycle before alignment
  assign hold_o    = rel_s_i && (cnt_q >= H_LO) && (cnt_q <= H_HI);
  assign aligned_o = (cnt_q == LAST);
endmodule

// File: rtl/qps_phase_seq.sv
module qps_phase_seq
  import qps_pkg::*;
#(
  parameter qvec_t INIT_VEC = Q1_V
) (
  input  logic  clk_i,
  input  logic  hold_i,
  output qvec_t phase_o
);
  qvec_t ph_q = INIT_VEC;
  qvec_t rot;
  qvec_t nxt;

  generate
    for (genvar i = 0; i < NUM_Q; i++) begin : g_rot
      assign rot[i] = ph_q[(i + NUM_Q - 1) % NUM_Q];
    end
  endgenerate

  always_comb begin
    if (!$onehot(ph_q))
      nxt = Q1_V;
    else if (hold_i && ph_q[0])
      nxt = ph_q;
    else
      nxt = rot;
  end

  always_ff @(posedge clk_i) ph_q <= nxt;

  assign phase_o = ph_q;
endmodule

// File: rtl/qps_align.sv
module qps_align #(
  parameter logic [3:0] INIT_VEC    = 4'b0001,
  parameter int         ALIGN_CYC   = 10,
  parameter int         HOLD_FROM   = 5,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rel_i,
  output logic [3:0] phase_o,
  output logic       aligned_o
);
  logic rel_sync;
  logic hold;

  qps_rel_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rel_i (rel_i),
    .rel_o (rel_sync)
  );

  qps_win_ctr #(.ALIGN_CYC(ALIGN_CYC), .HOLD_FROM(HOLD_FROM)) u_win (
    .clk_i     (clk_i),
    .rel_s_i   (rel_sync),
    .hold_o    (hold),
    .aligned_o (aligned_o)
  );

  qps_phase_seq #(.INIT_VEC(INIT_VEC)) u_seq (
    .clk_i   (clk_i),
    .hold_i  (hold),
    .phase_o (phase_o)
  );
endmodule

// File: rtl/qps_align_chk.sv
module qps_align_chk (
  input logic       clk_i,
  input logic       rel_i,
  input logic       rel_s,
  input logic [3:0] phase,
  input logic       aligned
);
  logic [1:0] age = '0;
  always_ff @(posedge clk_i) if (age != 2'd3) age <= age + 2'd1;

  AST_PHASE_ONEHOT: assert property (@(posedge clk_i) disable iff (age == 2'd0)
    $onehot(phase)); // R1
  AST_SHORT_PHASES: assert property (@(posedge clk_i) disable iff (age == 2'd0)
    !phase[0] |=> (phase == {$past(phase[2:0]), $past(phase[3])})); // R2
  AST_SYNC_DELAY: assert property (@(posedge clk_i) disable iff (age < 2'd2)
    rel_s == $past(rel_i, 2)); // R3
  AST_FREE_RUN: assert property (@(posedge clk_i) disable iff (age == 2'd0)
    (!rel_s && phase[0]) |=> phase[1]); // R4
  AST_ALIGN_IN_Q2: assert property (@(posedge clk_i) disable iff (age == 2'd0)
    $rose(aligned) |-> phase[1]); // R5
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (age == 2'd0)
    !rel_s |=> !aligned); // R6
  AST_ILLEGAL_FIX: assert property (@(posedge clk_i)
    !$onehot(phase) |=> (phase == 4'b0001)); // R7
endmodule

bind qps_align qps_align_chk chk_i (
  .clk_i   (clk_i),
  .rel_i   (rel_i),
  .rel_s   (rel_sync),
  .phase   (phase_o),
  .aligned (aligned_o)
);

// File: tb/qps_align_tb_top.sv
module qps_align_tb_top;
  localparam int NC = 5;
  localparam logic [3:0] INITS [NC] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0110};
  localparam int W1 = 8, W2 = 37, DROP = 25, LAST_K = 60;

  logic clk = 1'b0;
  logic rel = 1'b0;
  logic [3:0] ph [NC];
  logic       al [NC];

  always #4 clk = ~clk;

  generate
    for (genvar g = 0; g < NC; g++) begin : g_cp
      qps_align #(.INIT_VEC(INITS[g])) dut_i (
        .clk_i(clk), .rel_i(rel), .phase_o(ph[g]), .aligned_o(al[g]));
    end
  endgenerate

  typedef struct packed {
    int         k;
    logic [19:0] ph;
    logic       al;
    logic [3:0] tg;
  } item_t;

  item_t sbq[$];
  int checks = 0, errors = 0;
  int k = 0;
  int ex [NC] = '{0, 1, 2, 3, 0};
  int p0 [NC];

  function automatic string tag_s(input logic [3:0] t);
    case (t)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd7: return "R7";
      default: return "R?";
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s k=%0d actual=%0h expected=%0h", req, k, act, exp_v);
    end
  endtask

  // driver: pushes the expected state after each edge
  task automatic push_expected();
    item_t it;
    int c;
    logic [3:0] tg;
    c = -1;
    if (k >= W1 && k <= W1 + 10) c = k - W1;
    if (k >= W2 && k <= W2 + 10) c = k - W2;
    tg = (k < W1) ? 4'd4 : 4'd2;
    for (int i = 0; i < NC; i++) begin
      if (c == 0) begin
        ex[i] = (ex[i] + 1) % 4; p0[i] = ex[i];
      end else if (c > 0) begin
        if (c == 10) ex[i] = 1;
        else if (c >= 10 - (2 + p0[i])) ex[i] = 0;
        else ex[i] = (p0[i] + c) % 4;
      end else if (i == 4 && k == 1) begin
        ex[i] = 0;
      end else begin
        ex[i] = (ex[i] + 1) % 4;
      end
      it.ph[i*4 +: 4] = 4'b0001 << ex[i];
    end
    if (c == 0) tg = 4'd3;
    else if (c > 0) tg = 4'd5;
    if (k == 1) tg = 4'd7;
    it.k  = k;
    it.tg = tg;
    it.al = ((k >= W1 + 10) && (k < DROP + 3)) || (k >= W2 + 10);
    sbq.push_back(it);
  endtask

  always @(posedge clk) begin
    k <= k + 1;
    #1 push_expected();
  end

  // monitor: pops and compares away from the edge
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      for (int i = 0; i < NC; i++) begin
        chk((i == 4 && it.k == 1) ? "R7" : tag_s(it.tg), int'(ph[i]), int'(it.ph[i*4 +: 4]));
        chk("R6", int'(al[i]), int'(it.al));
      end
      if (it.k >= W1 + 10)
        for (int i = 1; i < NC; i++) chk("R8", int'(ph[i]), int'(ph[0]));
    end
  end

  initial begin
    #2;
    for (int i = 0; i < 4; i++) begin
      chk("R1", int'(ph[i]), int'(INITS[i]));
      chk("R1", int'(al[i]), 0);
    end
    while (k != 6) @(negedge clk);
    rel = 1'b1;
    while (k != DROP) @(negedge clk);
    rel = 1'b0;
    while (k != 35) @(negedge clk);
    rel = 1'b1;
    while (k != LAST_K) @(negedge clk);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog k=%0d actual=hung expected=done", k);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule